// File: doc/BRIEF.md
# Link Initialization Sequencer for a Multi-Lane 8b/10b Transmitter

This block steers the transmit side of a multi-lane serial converter link through its start-up phases. It watches an active-low resynchronization request from the receiver. While that request is pending, every active lane sends comma characters. Once the request is released, the block waits for the next multiframe boundary. It then sends a four-multiframe alignment pattern and finally hands the lanes over to user data. The block does not produce the encoded symbols itself. For each lane it tells the downstream 8b/10b encoder whether to send a control character and which one, whether the current octet is a configuration octet, and whether user data is valid.

The request can arrive on either of two inputs, picked by a select bit: a single-ended pin, or a differential pair that has already been turned into a logic level. The selected request is re-timed by a two-flop synchronizer before the sequencer uses it. When the link runs in 64b/66b mode, the request plays no part in start-up and the lanes go straight to data. The number of active lanes is an input; lanes above that count stay silent.

Top module: `lnk_init_ctrl`

## Requirements
- R1: `sync_sel`=0 makes `sync_se_n` the request source and `sync_diff_n` has no effect. `sync_sel`=1 makes `sync_diff_n` the source and `sync_se_n` has no effect.
- R2: The request passes through two flops. A change on the selected input cannot alter `link_phase` until the third rising clock edge after the change.
- R3: In the comma phase (`link_phase`=0), every active lane shows `tx_ctrl`=1 with `tx_code`=8'hBC (K28.5), `tx_valid`=0 and `tx_cfg`=0.
- R4: The comma phase is left only after the request has been seen low and then high. The alignment phase (`link_phase`=1) begins in a cycle where `mf_start`=1.
- R5: The alignment phase lasts exactly four multiframes of MF_LEN characters. The first character of each multiframe is control code 8'h1C (K28.0) and the last is control code 8'h7C (K28.3). Every other character has `tx_ctrl`=0 and `tx_code`=0, and those characters carry `tx_cfg`=1 only in the second multiframe.
- R6: In the data phase (`link_phase`=2), active lanes show `tx_valid`=1, `tx_ctrl`=0, `tx_cfg`=0 and `tx_code`=0.
- R7: In the data phase, a synchronized request held low for 4 consecutive cycles returns the link to the comma phase. A low run of 3 cycles leaves it in data.
- R8: While `mode_64b66b`=1, the phase becomes data on the next clock and stays there whatever the request does.
- R9: Lanes 0 to `active_lanes`-1 are active. All outputs of the other lanes are 0.
- R10: Reset (synchronous, active high) gives `link_phase`=0 and restarts the multiframe counter, so `mf_start`=1 in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_se_n | input | 1 | Single-ended request, active low |
| sync_diff_n | input | 1 | Request from the differential receiver, active low |
| sync_sel | input | 1 | Request source select |
| mode_64b66b | input | 1 | Bypasses request-driven start-up |
| active_lanes | input | $clog2(LANES+1) | Number of active lanes |
| link_phase | output | 2 | 0 comma, 1 alignment, 2 data |
| mf_start | output | 1 | First character of a multiframe |
| tx_ctrl | output | LANES | Per lane: send a control character |
| tx_cfg | output | LANES | Per lane: configuration octet |
| tx_valid | output | LANES | Per lane: user data valid |
| tx_code | output | 8*LANES | Per lane control code, lane i in bits 8i+7:8i |

## Verification
The bench first checks that a request that never went low cannot open the alignment phase. A sequencer that only looked at the level would leave the comma phase at once. It drives low runs of exactly three and exactly four cycles in data mode. An off-by-one in the run counter would either drop a healthy link or miss a real request. The alignment pattern is compared character by character against a scoreboard. This catches a start away from the boundary, a wrong marker placement, or configuration flags in the wrong multiframe. Toggling the unselected request source and holding the request low in 64b/66b mode shows up a wrong mux polarity or a bypass that leaks.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

    typedef enum logic [1:0] {
        PH_COMMA = 2'd0,
        PH_ALIGN = 2'd1,
        PH_DATA  = 2'd2
    } phase_t;

    localparam logic [7:0] CODE_COMMA  = 8'hBC;
    localparam logic [7:0] CODE_MF_BEG = 8'h1C;
    localparam logic [7:0] CODE_MF_END = 8'h7C;

    localparam int ALIGN_MFS  = 4;
    localparam int CFG_MF_IDX = 1;

    typedef struct packed {
        logic       ctrl;
        logic       cfg;
        logic       valid;
        logic [7:0] code;
    } lane_ctl_t;

    function automatic lane_ctl_t lane_word(phase_t ph, logic first, logic last,
                                            logic [1:0] mf_idx);
        lane_ctl_t w;
        w = '0;
        case (ph)
            PH_COMMA: begin
                w.ctrl = 1'b1;
                w.code = CODE_COMMA;
            end
            PH_ALIGN: begin
                if (first) begin
                    w.ctrl = 1'b1;
                    w.code = CODE_MF_BEG;
                end else if (last) begin
                    w.ctrl = 1'b1;
                    w.code = CODE_MF_END;
                end else begin
                    w.cfg = (mf_idx == 2'(CFG_MF_IDX));
                end
            end
            PH_DATA:  w.valid = 1'b1;
            default:  w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/lnk_sync_cdc.sv
module lnk_sync_cdc (
    input  logic clk,
    input  logic rst,
    input  logic sel,
    input  logic se_n,
    input  logic diff_n,
    output logic req_high
);
    logic picked;
    logic [1:0] stage;

    assign picked = sel ? diff_n : se_n;

    always_ff @(posedge clk) begin
        if (rst) stage <= 2'b11;
        else     stage <= {stage[0], picked};
    end

    assign req_high = stage[1];
endmodule

// File: rtl/lnk_mf_timer.sv
module lnk_mf_timer #(
    parameter int MF_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    output logic first,
    output logic last
);
    localparam int POS_W = (MF_LEN > 1) ? $clog2(MF_LEN) : 1;
    logic [POS_W-1:0] pos;

    always_ff @(posedge clk) begin
        if (rst)                         pos <= '0;
        else if (pos == POS_W'(MF_LEN-1)) pos <= '0;
        else                             pos <= pos + 1'b1;
    end

    assign first = (pos == '0);
    assign last  = (pos == POS_W'(MF_LEN-1));
endmodule

// File: rtl/lnk_seq_fsm.sv
module lnk_seq_fsm
    import lnk_pkg::*;
#(
    parameter int RELINK_LOW = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_high,
    input  logic       wide_mode,
    input  logic       mf_first,
    input  logic       mf_last,
    output phase_t     phase,
    output logic [1:0] mf_idx
);
    localparam int LOW_W = (RELINK_LOW > 1) ? $clog2(RELINK_LOW) : 1;

    logic [LOW_W-1:0] low_run;
    logic             saw_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_COMMA;
            mf_idx  <= '0;
            low_run <= '0;
            saw_low <= 1'b0;
        end else if (wide_mode) begin
            phase   <= PH_DATA;
            low_run <= '0;
            saw_low <= 1'b0;
        end else begin
            case (phase)
                PH_COMMA: begin
                    if (!req_high) saw_low <= 1'b1;
                    if (req_high && saw_low && mf_last) begin
                        phase   <= PH_ALIGN;
                        mf_idx  <= '0;
                        saw_low <= 1'b0;
                    end
                end
                PH_ALIGN: begin
                    if (mf_last) begin
                        if (mf_idx == 2'(ALIGN_MFS-1)) phase <= PH_DATA;
                        else                           mf_idx <= mf_idx + 1'b1;
                    end
                end
                default: begin
                    if (req_high) begin
                        low_run <= '0;
                    end else if (low_run == LOW_W'(RELINK_LOW-1)) begin
                        phase   <= PH_COMMA;
                        low_run <= '0;
                        saw_low <= 1'b1;
                    end else begin
                        low_run <= low_run + 1'b1;
                    end
                end
            endcase
        end
    end

    AST_ALIGN_ON_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ALIGN && $past(phase) != PH_ALIGN) |-> mf_first); // R4
    AST_ALIGN_NEEDS_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ALIGN && $past(phase) == PH_COMMA) |-> ($past(req_high) && $past(saw_low))); // R4
    AST_ALIGN_FULL_LENGTH: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DATA && $past(phase) == PH_ALIGN) |-> ($past(mf_idx) == 2'(ALIGN_MFS-1) && $past(mf_last))); // R5
    AST_RELINK_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_COMMA && $past(phase) == PH_DATA) |-> (!$past(req_high) && $past(low_run) == LOW_W'(RELINK_LOW-1))); // R7
    AST_WIDE_STAYS_DATA: assert property (@(posedge clk) disable iff (rst)
        ($past(wide_mode) && !$past(rst)) |-> phase == PH_DATA); // R8
endmodule

// File: rtl/lnk_lane_map.sv
module lnk_lane_map
    import lnk_pkg::*;
#(
    parameter int LANES = 4,
    parameter int CNT_W = 3
) (
    input  phase_t             phase,
    input  logic               mf_first,
    input  logic               mf_last,
    input  logic [1:0]         mf_idx,
    input  logic [CNT_W-1:0]   active_lanes,
    output logic [LANES-1:0]   ctrl,
    output logic [LANES-1:0]   cfg,
    output logic [LANES-1:0]   valid,
    output logic [8*LANES-1:0] code
);
    lane_ctl_t shared;
    assign shared = lane_word(phase, mf_first, mf_last, mf_idx);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic      on;
        lane_ctl_t w;
        assign on            = (CNT_W'(i) < active_lanes);
        assign w             = on ? shared : '0;
        assign ctrl[i]       = w.ctrl;
        assign cfg[i]        = w.cfg;
        assign valid[i]      = w.valid;
        assign code[8*i +: 8] = w.code;
    end
endmodule

// File: rtl/lnk_init_ctrl.sv
module lnk_init_ctrl
    import lnk_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int MF_LEN     = 4,
    parameter int RELINK_LOW = 4,
    localparam int CNT_W     = $clog2(LANES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sync_se_n,
    input  logic               sync_diff_n,
    input  logic               sync_sel,
    input  logic               mode_64b66b,
    input  logic [CNT_W-1:0]   active_lanes,
    output logic [1:0]         link_phase,
    output logic               mf_start,
    output logic [LANES-1:0]   tx_ctrl,
    output logic [LANES-1:0]   tx_cfg,
    output logic [LANES-1:0]   tx_valid,
    output logic [8*LANES-1:0] tx_code
);
    logic       req_high, mf_first, mf_last;
    logic [1:0] mf_idx;
    phase_t     phase;

    lnk_sync_cdc u_cdc (
        .clk(clk), .rst(rst), .sel(sync_sel),
        .se_n(sync_se_n), .diff_n(sync_diff_n), .req_high(req_high)
    );

    lnk_mf_timer #(.MF_LEN(MF_LEN)) u_timer (
        .clk(clk), .rst(rst), .first(mf_first), .last(mf_last)
    );

    lnk_seq_fsm #(.RELINK_LOW(RELINK_LOW)) u_fsm (
        .clk(clk), .rst(rst), .req_high(req_high), .wide_mode(mode_64b66b),
        .mf_first(mf_first), .mf_last(mf_last), .phase(phase), .mf_idx(mf_idx)
    );

    lnk_lane_map #(.LANES(LANES), .CNT_W(CNT_W)) u_lanes (
        .phase(phase), .mf_first(mf_first), .mf_last(mf_last), .mf_idx(mf_idx),
        .active_lanes(active_lanes), .ctrl(tx_ctrl), .cfg(tx_cfg),
        .valid(tx_valid), .code(tx_code)
    );

    assign link_phase = phase;
    assign mf_start   = mf_first;
endmodule

// File: tb/lnk_init_ctrl_test.sv
module lnk_init_ctrl_test;
    localparam int PERIOD = 10;
    localparam int LANES  = 4;
    localparam int MF_LEN = 4;
    localparam int CNT_W  = $clog2(LANES + 1);

    logic clk = 1'b0;
    logic rst, sync_se_n, sync_diff_n, sync_sel, mode_64b66b;
    logic [CNT_W-1:0]   active_lanes;
    logic [1:0]         link_phase;
    logic               mf_start;
    logic [LANES-1:0]   tx_ctrl, tx_cfg, tx_valid;
    logic [8*LANES-1:0] tx_code;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        logic [1:0] ph;
        logic       ctrl;
        logic       cfg;
        logic       valid;
        logic [7:0] code;
        string      req;
    } exp_t;
    exp_t q[$];

    always #(PERIOD/2) clk = ~clk;

    lnk_init_ctrl #(.LANES(LANES), .MF_LEN(MF_LEN), .RELINK_LOW(4)) uut (
        .clk(clk), .rst(rst), .sync_se_n(sync_se_n), .sync_diff_n(sync_diff_n),
        .sync_sel(sync_sel), .mode_64b66b(mode_64b66b), .active_lanes(active_lanes),
        .link_phase(link_phase), .mf_start(mf_start), .tx_ctrl(tx_ctrl),
        .tx_cfg(tx_cfg), .tx_valid(tx_valid), .tx_code(tx_code)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] lane_pack(int i);
        return {tx_ctrl[i], tx_cfg[i], tx_valid[i], tx_code[8*i +: 8]};
    endfunction

    task automatic lanes_chk(string req, logic c, logic f, logic v, logic [7:0] cd);
        for (int i = 0; i < LANES; i++) begin
            if (i < int'(active_lanes)) chk(req, int'(lane_pack(i)), int'({c, f, v, cd}));
            else                        chk({req, " R9 idle lane"}, int'(lane_pack(i)), 0);
        end
    endtask

    // Scoreboard monitor: compares each pending expected item one unit after the falling edge.
    always @(negedge clk) begin
        #1;
        if (q.size() != 0) begin
            exp_t e;
            e = q.pop_front();
            chk({e.req, " phase"}, int'(link_phase), int'(e.ph));
            lanes_chk(e.req, e.ctrl, e.cfg, e.valid, e.code);
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_item(logic [1:0] ph, logic c, logic f, logic v, logic [7:0] cd, string req);
        exp_t e;
        e.ph = ph; e.ctrl = c; e.cfg = f; e.valid = v; e.code = cd; e.req = req;
        q.push_back(e);
    endtask

    // Driver: after the request is released, wait for alignment and queue its full pattern.
    task automatic expect_align();
        int n = 0;
        while (link_phase != 2'd1 && n < MF_LEN + 8) begin
            @(negedge clk);
            n++;
        end
        chk("R4 alignment reached", int'(link_phase), 1);
        chk("R2 alignment not before third edge", int'(n >= 3), 1);
        chk("R4 alignment on boundary", int'(mf_start), 1);
        for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < MF_LEN; p++) begin
                if (p == 0)               push_item(2'd1, 1'b1, 1'b0, 1'b0, 8'h1C, "R5 mf start");
                else if (p == MF_LEN - 1) push_item(2'd1, 1'b1, 1'b0, 1'b0, 8'h7C, "R5 mf end");
                else                      push_item(2'd1, 1'b0, (m == 1), 1'b0, 8'h00, "R5 mf body");
            end
        end
        push_item(2'd2, 1'b0, 1'b0, 1'b1, 8'h00, "R6 data");
        push_item(2'd2, 1'b0, 1'b0, 1'b1, 8'h00, "R6 data");
        while (q.size() != 0) @(negedge clk);
        #2;
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; sync_se_n = 1'b1; sync_diff_n = 1'b1; sync_sel = 1'b0;
        mode_64b66b = 1'b0; active_lanes = CNT_W'(3);
        cycles(3);
        rst = 1'b0;
        #1;
        chk("R10 reset phase", int'(link_phase), 0);
        chk("R10 reset mf_start", int'(mf_start), 1);
        lanes_chk("R3 comma after reset", 1'b1, 1'b0, 1'b0, 8'hBC);

        // Request never went low: must stay in comma phase.
        cycles(3 * MF_LEN);
        #1;
        chk("R4 no release without low", int'(link_phase), 0);

        @(negedge clk); sync_se_n = 1'b0;
        cycles(5);
        #1;
        chk("R3 comma while requested", int'(link_phase), 0);
        lanes_chk("R3 comma chars", 1'b1, 1'b0, 1'b0, 8'hBC);
        @(negedge clk); sync_se_n = 1'b1;
        expect_align();

        // Three-cycle low run is not a relink.
        @(negedge clk); sync_se_n = 1'b0;
        cycles(3); sync_se_n = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk); #1;
            chk("R7 short low kept data", int'(link_phase), 2);
        end

        // Four-cycle low run relinks.
        @(negedge clk); sync_se_n = 1'b0;
        cycles(4); sync_se_n = 1'b1;
        cycles(2); #1;
        chk("R7 four low relinks", int'(link_phase), 0);
        expect_align();

        // Source select: differential input in charge.
        @(negedge clk); sync_sel = 1'b1; sync_se_n = 1'b0;
        cycles(10); #1;
        chk("R1 unselected single-ended ignored", int'(link_phase), 2);
        @(negedge clk); sync_diff_n = 1'b0;
        cycles(4); sync_diff_n = 1'b1;
        cycles(2); #1;
        chk("R1 differential request honoured", int'(link_phase), 0);
        expect_align();
        @(negedge clk); sync_sel = 1'b0; sync_diff_n = 1'b0;
        cycles(6); #1;
        chk("R1 single-ended selected again", int'(link_phase), 0);

        // 64b/66b bypass while request held low.
        @(negedge clk); mode_64b66b = 1'b1;
        @(negedge clk); #1;
        chk("R8 bypass to data", int'(link_phase), 2);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk); #1;
            chk("R8 request ignored", int'(link_phase), 2);
        end
        lanes_chk("R6 data lanes", 1'b0, 1'b0, 1'b1, 8'h00);

        active_lanes = CNT_W'(LANES);
        #1;
        lanes_chk("R9 all lanes", 1'b0, 1'b0, 1'b1, 8'h00);
        active_lanes = CNT_W'(0);
        #1;
        lanes_chk("R9 no lanes", 1'b0, 1'b0, 1'b1, 8'h00);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule